// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

A register-mapped peripheral that keeps a free-running seconds count and raises an alarm when that count reaches a programmed value. An internal prescaler turns the bus clock into one tick every `TICK_DIV` cycles. Each tick advances the count, which wraps modulo 2^DATA_W. Software sets the time through a load register and the alarm point through a match register. It reads the raw alarm flag and the masked alarm flag, and acknowledges an alarm through a write-one-to-clear register. A single level interrupt follows the masked flag.

The block sits on a simple APB-style bus with a 4 KB window. A transfer takes effect when `psel_i` and `penable_i` are both high. A write updates state on the rising edge that ends the access phase. Read data is combinational from the address and the current register state during the access phase. Equality between count and match is evaluated on every edge where the count or the match value changes, whether through a tick, a load write or a match write. The comparison uses the values those registers take on that edge, so an alarm is never one tick late.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset the count, match, load and mask registers and the raw alarm flag are zero, and `irq_o` is low.
- R2: Offset 0x00 reads the count. The count increments on every `TICK_DIV`-th rising clock edge after reset release, the first increment falling on edge `TICK_DIV`. It wraps from all ones to zero.
- R3: A write to offset 0x08 sets the count to the written value on the completing edge. A read of 0x08 returns the last value written there.
- R4: When a load write and a tick fall on the same edge, the count takes the loaded value.
- R5: A write to offset 0x04 stores the match value. On any edge where the count or match changes, bit 0 of the raw flag (offset 0x14) is set if the updated count equals the updated match. This holds across the wrap.
- R6: Offset 0x10 stores only bit 0 (mask, 1 = enabled); its other bits read as zero.
- R7: Offset 0x18 bit 0 reads raw AND mask, and `irq_o` is that same level.
- R8: Writing 1 to bit 0 of offset 0x1C clears the raw flag. Reading 0x1C returns 0.
- R9: When an alarm set and a clear fall on the same edge, the raw flag stays set.
- R10: Offset 0x0C always reads 1 and ignores writes. Writes to 0x00, 0x14 and 0x18 change nothing.
- R11: Offsets 0xFE0, 0xFE4 … 0xFFC read the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, one per word, zero-extended. Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte offset in the 4 KB window |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data, valid in the access phase |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The bench lines up a load write with a tick edge. A design that let the tick win would read back the loaded value plus one. It also lines up an alarm clear with the tick that makes the count reach the match value. A design that let the clear win would lose that alarm, leaving the raw flag and `irq_o` low.

A match write equal to the current count must set the raw flag at once. A design that compared only on ticks would wait for a wrap that never comes. The wrap from all ones to zero is crossed with a match value just past it, which exposes a signed or saturating comparison.

Writes to the control, count and status offsets, and an all-ones mask write, are each followed by reads of the state they could have touched. These catch a decoder that aliases offsets or stores the upper mask bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int WIN_W = 12;

  localparam logic [WIN_W-1:0] OFS_COUNT = 12'h000;
  localparam logic [WIN_W-1:0] OFS_MATCH = 12'h004;
  localparam logic [WIN_W-1:0] OFS_LOAD  = 12'h008;
  localparam logic [WIN_W-1:0] OFS_CTRL  = 12'h00C;
  localparam logic [WIN_W-1:0] OFS_MASK  = 12'h010;
  localparam logic [WIN_W-1:0] OFS_RAW   = 12'h014;
  localparam logic [WIN_W-1:0] OFS_MIS   = 12'h018;
  localparam logic [WIN_W-1:0] OFS_CLR   = 12'h01C;
  localparam logic [6:0]       ID_PAGE   = 7'h7F;  // addr[11:5] of 0xFE0..0xFFF

  typedef struct packed {
    logic load;
    logic match;
    logic mask;
    logic clear;
  } wr_strb_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_DIV = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick_o = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  wr_strb_t          wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] match_o,
  output logic [DATA_W-1:0] load_o,
  output logic              mask_o,
  output logic              raw_o
);
  logic [DATA_W-1:0] count_q, match_q, load_q;
  logic [DATA_W-1:0] count_d, match_d;
  logic              mask_q, raw_q;
  logic              hit_set;

  // load beats tick
  always_comb begin
    if (wr_i.load)   count_d = wdata_i;
    else if (tick_i) count_d = count_q + 1'b1;
    else             count_d = count_q;
    match_d = wr_i.match ? wdata_i : match_q;
    hit_set = (tick_i | wr_i.load | wr_i.match) && (count_d == match_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      match_q <= '0;
      load_q  <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      match_q <= match_d;
      if (wr_i.load) load_q <= wdata_i;
      if (wr_i.mask) mask_q <= wdata_i[0];
      // set beats clear
      if (hit_set)                        raw_q <= 1'b1;
      else if (wr_i.clear && wdata_i[0])  raw_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign match_o = match_q;
  assign load_o  = load_q;
  assign mask_o  = mask_q;
  assign raw_o   = raw_q;
endmodule

// File: rtl/rtc_rdmux.sv
module rtc_rdmux
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [WIN_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] match_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              mask_i,
  input  logic              raw_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i[WIN_W-1:5] == ID_PAGE && addr_i[1:0] == 2'b00) begin
      rdata_o = DATA_W'(id_byte(addr_i[4:2]));
    end else begin
      case (addr_i)
        OFS_COUNT: rdata_o = count_i;
        OFS_MATCH: rdata_o = match_i;
        OFS_LOAD:  rdata_o = load_i;
        OFS_CTRL:  rdata_o = DATA_W'(1);
        OFS_MASK:  rdata_o = DATA_W'(mask_i);
        OFS_RAW:   rdata_o = DATA_W'(raw_i);
        OFS_MIS:   rdata_o = DATA_W'(raw_i & mask_i);
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
  import rtc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_DIV = 100_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [11:0]       paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              irq_o
);
  logic              tick;
  logic              wr_en;
  wr_strb_t          wr_strb;
  logic [DATA_W-1:0] count_q, match_q, load_q;
  logic              mask_q, raw_q;

  assign wr_en = psel_i & penable_i & pwrite_i;

  always_comb begin
    wr_strb.load  = wr_en && (paddr_i == OFS_LOAD);
    wr_strb.match = wr_en && (paddr_i == OFS_MATCH);
    wr_strb.mask  = wr_en && (paddr_i == OFS_MASK);
    wr_strb.clear = wr_en && (paddr_i == OFS_CLR);
  end

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  rtc_core #(.DATA_W(DATA_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_i    (wr_strb),
    .wdata_i (pwdata_i),
    .count_o (count_q),
    .match_o (match_q),
    .load_o  (load_q),
    .mask_o  (mask_q),
    .raw_o   (raw_q)
  );

  rtc_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .addr_i  (paddr_i),
    .count_i (count_q),
    .match_i (match_q),
    .load_i  (load_q),
    .mask_i  (mask_q),
    .raw_i   (raw_q),
    .rdata_o (prdata_o)
  );

  assign irq_o = raw_q & mask_q;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [11:0]       paddr_i,
  input logic [DATA_W-1:0] pwdata_i,
  input logic [DATA_W-1:0] prdata_i,
  input logic              irq_i,
  input logic              tick_i,
  input logic [DATA_W-1:0] count_i,
  input logic [DATA_W-1:0] match_i,
  input logic              raw_i
);
  logic acc, wr, rd;
  assign acc = psel_i & penable_i;
  assign wr  = acc & pwrite_i;
  assign rd  = acc & ~pwrite_i;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (count_i == '0 && raw_i == 1'b0 && irq_i == 1'b0));

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(wr && paddr_i == OFS_LOAD)) |=> count_i == $past(count_i) + 1'b1);

  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(wr && paddr_i == OFS_LOAD)) |=> $stable(count_i));

  assert_load_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && paddr_i == OFS_LOAD) |=> count_i == $past(pwdata_i));

  assert_alarm_on_equal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_i) |-> count_i == match_i);

  assert_mask_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && paddr_i == OFS_MASK) |-> prdata_i[DATA_W-1:1] == '0);

  assert_irq_needs_raw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> raw_i);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && paddr_i == OFS_CLR && pwdata_i[0] && !tick_i &&
     !(paddr_i == OFS_LOAD) && !(paddr_i == OFS_MATCH)) |=> !raw_i);

  assert_ctrl_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && paddr_i == OFS_CTRL) |-> prdata_i == DATA_W'(1));

  assert_id_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && paddr_i == 12'hFE0) |-> prdata_i == DATA_W'(8'h31));
endmodule

bind sec_alarm_rtc rtc_checker #(.DATA_W(DATA_W)) u_rtc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .pwdata_i  (pwdata_i),
  .prdata_i  (prdata_o),
  .irq_i     (irq_o),
  .tick_i    (tick),
  .count_i   (count_q),
  .match_i   (match_q),
  .raw_i     (raw_q)
);

// File: tb/sec_alarm_rtc_bench.sv
module sec_alarm_rtc_bench;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, pen = 1'b0, pwr = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sec_alarm_rtc #(.DATA_W(32), .TICK_DIV(D)) u_sec_alarm_rtc (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(pen), .pwrite_i(pwr),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .irq_o(irq)
  );

  // reference model built from the requirements
  int unsigned k;
  logic [31:0] m_cnt, m_mat, m_ld;
  logic        m_msk, m_raw;

  always @(posedge clk) begin
    logic tk, w, ld, mw, set;
    logic [31:0] nc, nm;
    if (!rst_n) begin
      k = 0; m_cnt = 0; m_mat = 0; m_ld = 0; m_msk = 0; m_raw = 0;
    end else begin
      k++;
      tk = (k % D == 0);
      w  = psel && pen && pwr;
      ld = w && paddr == 12'h008;
      mw = w && paddr == 12'h004;
      nc = ld ? pwdata : (tk ? m_cnt + 1 : m_cnt);
      nm = mw ? pwdata : m_mat;
      set = (tk || ld || mw) && nc == nm;
      if (set) m_raw = 1;
      else if (w && paddr == 12'h01C && pwdata[0]) m_raw = 0;
      if (w && paddr == 12'h010) m_msk = pwdata[0];
      if (ld) m_ld = pwdata;
      m_cnt = nc; m_mat = nm;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 12'hFE0 && a[1:0] == 0) return {24'h0, ids[a[4:2]]};
    case (a)
      12'h000: return m_cnt;
      12'h004: return m_mat;
      12'h008: return m_ld;
      12'h00C: return 32'd1;
      12'h010: return {31'h0, m_msk};
      12'h014: return {31'h0, m_raw};
      12'h018: return {31'h0, m_raw & m_msk};
      default: return 32'h0;
    endcase
  endfunction

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (psel && pen && !pwr) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (prdata !== e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, paddr, prdata, e);
      end
    end
  end

  task automatic rd_push(input logic [11:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1 psel = 1; pen = 0; pwr = 0; paddr = a;
    @(posedge clk); #1 pen = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 psel = 0; pen = 0;
  endtask

  // expected from the model at the sampled cycle
  task automatic rd(input logic [11:0] a, input string t);
    @(posedge clk); #1 psel = 1; pen = 0; pwr = 0; paddr = a;
    @(posedge clk); #1 pen = 1;
    exp_q.push_back(exp_rd(a)); tag_q.push_back(t);
    @(posedge clk); #1 psel = 0; pen = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 psel = 1; pen = 0; pwr = 1; paddr = a; pwdata = d;
    @(posedge clk); #1 pen = 1;
    @(posedge clk); #1 psel = 0; pen = 0; pwr = 0;
  endtask

  // after return, a write started now completes on edge k+3 with (k+3)%D == ph
  task automatic align(input int ph);
    do begin @(posedge clk); #1; end while ((k + 3) % D != ph);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd_push(12'h004, 32'h0, "R1 match reset");
    rd_push(12'h008, 32'h0, "R1 load reset");
    rd_push(12'h010, 32'h0, "R1 mask reset");
    rd_push(12'h014, 32'h0, "R1 raw reset");

    // R2 free-running count
    repeat (3 * D) @(posedge clk);
    rd(12'h000, "R2 count advance");

    // R11 identification and undefined offsets
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i), "R11 id byte");
    rd_push(12'h020, 32'h0, "R11 undefined offset");
    rd_push(12'hFDC, 32'h0, "R11 below id page");
    rd_push(12'hFE2, 32'h0, "R11 unaligned id");

    // R3 load then read back
    align(5);
    wr(12'h008, 32'h0000_1234);
    rd_push(12'h008, 32'h0000_1234, "R3 load readback");
    rd(12'h000, "R3 count after load");

    // R5 match write equal to current count sets at once
    align(4);
    wr(12'h008, 32'h0000_0100);
    wr(12'h004, 32'h0000_0100);
    rd_push(12'h014, 32'h1, "R5 immediate match");
    rd_push(12'h004, 32'h0000_0100, "R5 match readback");

    // R7 masked status and irq
    rd_push(12'h018, 32'h0, "R7 masked while disabled");
    chk_irq(1'b0, "R7 irq masked off");
    wr(12'h010, 32'hFFFF_FFFF);
    rd_push(12'h010, 32'h1, "R6 only bit0 kept");
    rd_push(12'h018, 32'h1, "R7 masked status");
    chk_irq(1'b1, "R7 irq level");

    // R10 ignored writes
    wr(12'h00C, 32'h0);
    rd_push(12'h00C, 32'h1, "R10 ctrl reads one");
    wr(12'h014, 32'h0);
    wr(12'h018, 32'h0);
    rd_push(12'h014, 32'h1, "R10 raw write ignored");
    align(4);
    wr(12'h000, 32'hDEAD_BEEF);
    rd(12'h000, "R10 count write ignored");

    // R8 clear
    wr(12'h01C, 32'h1);
    rd_push(12'h014, 32'h0, "R8 raw cleared");
    rd_push(12'h01C, 32'h0, "R8 clear reads zero");
    chk_irq(1'b0, "R8 irq dropped");

    // R5 alarm reached by ticks
    align(4);
    wr(12'h008, 32'd5);
    wr(12'h004, 32'd7);
    rd_push(12'h014, 32'h0, "R5 not yet");
    repeat (2 * D + 2) @(posedge clk);
    rd_push(12'h014, 32'h1, "R5 tick alarm");
    rd(12'h000, "R2 count after ticks");
    chk_irq(1'b1, "R7 irq from tick alarm");
    wr(12'h01C, 32'h1);

    // R2/R5 wrap
    align(4);
    wr(12'h008, 32'hFFFF_FFFE);
    wr(12'h004, 32'h0000_0001);
    wr(12'h01C, 32'h1);
    repeat (3 * D + 2) @(posedge clk);
    rd_push(12'h014, 32'h1, "R5 alarm across wrap");
    rd(12'h000, "R2 wrapped count");
    wr(12'h01C, 32'h1);

    // R4 load coinciding with tick
    align(0);
    wr(12'h008, 32'h0000_0A00);
    rd_push(12'h000, 32'h0000_0A00, "R4 load beats tick");

    // R9 clear coinciding with alarm set
    align(4);
    wr(12'h008, 32'h0000_0050);
    wr(12'h004, 32'h0000_0051);
    wr(12'h01C, 32'h1);
    align(0);
    wr(12'h01C, 32'h1);
    rd_push(12'h014, 32'h1, "R9 set beats clear");
    chk_irq(1'b1, "R9 irq kept");

    repeat (4) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule